// File: doc/BRIEF.md
# Ping-pong data link message buffer

This block stages outgoing data-link messages in two alternating transmit buffers. A host fills them through a small register interface. The host first reads a status register to learn which buffer is next. It then pushes the message bytes into that buffer's data register, which moves to the next location on every write, so no address register is needed. Finally it writes the byte count, which hands the filled buffer to a byte-wide drain port feeding a serializer.

The same two data offsets are split by direction. A host write goes to transmit storage. A host read pops the oldest byte from a small receive queue, which a deserializer fills through its own input. Flag framing, bit stuffing, checksums and DMA belong to neighbouring blocks.

Top module: `dl_msg_pingpong`

## Requirements
- R1: After reset the status register (offset 0) reads 0x00 and `drain_valid_o` is low. Status bits are: bit 0 next buffer to fill, bit 1 busy, bit 2 buffer 0 overflow, bit 3 buffer 1 overflow, bit 4 count rejected, bit 5 receive byte available.
- R2: Host writes to offset 6 fill buffer 0 and host writes to offset 7 fill buffer 1, at consecutive locations starting at 0. The drain port presents the committed bytes in location order.
- R3: Writes past the 96th byte of a buffer are dropped and set that buffer's sticky overflow bit. Writing 1 to a sticky status bit at offset 0 clears it.
- R4: Writing a count from 1 to 96 to offset 1 commits the buffer named by status bit 0, makes it available on the drain port, and toggles status bit 0 to the other buffer.
- R5: A count of 0 or above 96 is not committed. It leaves status bit 0 and the drain port unchanged and sets the sticky reject bit (bit 4).
- R6: While the buffer named by status bit 0 is still committed, status bit 1 reads 1. Count writes are then rejected, and data writes to a committed buffer are dropped.
- R7: While `drain_valid_o` is high and `drain_ready_i` is low, the data and last outputs hold. `drain_last_o` marks byte count-1. The buffer becomes free once that byte is accepted.
- R8: Committed buffers drain in the order they were committed, alternating 0 and 1.
- R9: A commit resets the buffer's write location, so the next fill of that buffer starts again at location 0.
- R10: A host read of offset 6 or 7 returns the oldest received byte and removes it. It returns 0x00 when the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Host register write strobe |
| reg_rd_i | input | 1 | Host register read strobe |
| reg_addr_i | input | 4 | Host register offset |
| reg_wdata_i | input | 8 | Host write data |
| reg_rdata_o | output | 8 | Host read data, combinational from the offset |
| rx_valid_i | input | 1 | Received byte strobe from deserializer |
| rx_data_i | input | 8 | Received byte |
| drain_valid_o | output | 1 | Transmit byte available |
| drain_data_o | output | 8 | Transmit byte |
| drain_last_o | output | 1 | Final byte of the current message |
| drain_ready_i | input | 1 | Serializer accepts the byte |

## Verification
The bench fills a buffer two bytes past its limit and checks that byte 95 drains intact. A design that let the pointer wrap would overwrite location 0, and one that clamped badly would corrupt the tail. It commits both buffers while the drain is stalled, then checks the busy indication, the rejection of a further count, and that a stray data write does not reach the held buffer. A design that ignored the held state would then drain the wrong bytes. Refilling a buffer with a shorter message after a longer one shows whether the write location was reset at commit. Invalid counts of 0 and 97 must leave the drain port silent.

// File: rtl/dl_pkg.sv
`timescale 1ns/1ps
package dl_pkg;
  localparam int unsigned ADDR_W = 4;

  localparam logic [ADDR_W-1:0] OFF_STATUS = 4'h0;
  localparam logic [ADDR_W-1:0] OFF_COUNT  = 4'h1;
  localparam logic [ADDR_W-1:0] OFF_DATA0  = 4'h6;
  localparam logic [ADDR_W-1:0] OFF_DATA1  = 4'h7;

  localparam int unsigned ST_SEL  = 0;
  localparam int unsigned ST_BUSY = 1;
  localparam int unsigned ST_OVF0 = 2;
  localparam int unsigned ST_REJ  = 4;
  localparam int unsigned ST_RXAV = 5;

  typedef enum logic {
    BANK_FREE = 1'b0,
    BANK_HELD = 1'b1
  } bank_state_e;
endpackage

// File: rtl/dl_tx_bank.sv
`timescale 1ns/1ps
module dl_tx_bank
  import dl_pkg::*;
#(
  parameter int unsigned DEPTH  = 96,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned PTR_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              commit_i,
  input  logic [PTR_W-1:0]  count_i,
  input  logic              pop_i,
  input  logic              ovf_clr_i,
  output logic              free_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              last_o,
  output logic              ovf_o
);
  bank_state_e       state_q;
  logic [PTR_W-1:0]  wptr_q, rptr_q, cnt_q;
  logic              ovf_q;
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic              is_free, room, wr_ok;

  assign is_free = (state_q == BANK_FREE);
  assign room    = (wptr_q < PTR_W'(DEPTH));
  assign wr_ok   = wr_i & is_free & room;

  always_ff @(posedge clk_i) begin
    if (wr_ok) mem_q[wptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= BANK_FREE;
      wptr_q  <= '0;
      rptr_q  <= '0;
      cnt_q   <= '0;
      ovf_q   <= 1'b0;
    end else begin
      if (is_free) begin
        if (commit_i) begin
          state_q <= BANK_HELD;
          cnt_q   <= count_i;
          wptr_q  <= '0;
          rptr_q  <= '0;
        end else if (wr_ok) begin
          wptr_q <= wptr_q + PTR_W'(1);
        end
      end else if (pop_i) begin
        if (last_o) begin
          state_q <= BANK_FREE;
          rptr_q  <= '0;
        end else begin
          rptr_q <= rptr_q + PTR_W'(1);
        end
      end
      // set wins over clear
      if (wr_i && is_free && !room) ovf_q <= 1'b1;
      else if (ovf_clr_i)           ovf_q <= 1'b0;
    end
  end

  assign free_o  = is_free;
  assign rdata_o = mem_q[rptr_q];
  assign last_o  = !is_free && (rptr_q == cnt_q - PTR_W'(1));
  assign ovf_o   = ovf_q;
endmodule

// File: rtl/dl_rx_fifo.sv
`timescale 1ns/1ps
module dl_rx_fifo #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pop_i,
  output logic              empty_o,
  output logic [DATA_W-1:0] head_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     wp_q, rp_q;
  logic [AW:0]       cnt_q;
  logic              full, push_ok, pop_ok;

  assign full    = (cnt_q == (AW+1)'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign push_ok = push_i & ~full;
  assign pop_ok  = pop_i & ~empty_o;
  assign head_o  = mem_q[rp_q];

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wp_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wp_q <= (wp_q == AW'(DEPTH-1)) ? '0 : wp_q + AW'(1);
      if (pop_ok)  rp_q <= (rp_q == AW'(DEPTH-1)) ? '0 : rp_q + AW'(1);
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + (AW+1)'(1);
        2'b01:   cnt_q <= cnt_q - (AW+1)'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/dl_host_regs.sv
`timescale 1ns/1ps
module dl_host_regs
  import dl_pkg::*;
#(
  parameter int unsigned DEPTH  = 96,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned PTR_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [1:0]        free_i,
  input  logic [1:0]        ovf_i,
  input  logic              rx_empty_i,
  input  logic [DATA_W-1:0] rx_head_i,
  output logic [1:0]        bank_wr_o,
  output logic [1:0]        commit_o,
  output logic [PTR_W-1:0]  count_o,
  output logic [1:0]        ovf_clr_o,
  output logic              rx_pop_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic fill_q, rej_q;
  logic wr_cnt, wr_stat, cnt_ok, commit_go, data_off;

  assign wr_cnt    = wr_i && (addr_i == OFF_COUNT);
  assign wr_stat   = wr_i && (addr_i == OFF_STATUS);
  assign cnt_ok    = (wdata_i != '0) && (wdata_i <= DATA_W'(DEPTH));
  assign commit_go = wr_cnt && cnt_ok && free_i[fill_q];
  assign count_o   = wdata_i[PTR_W-1:0];
  assign data_off  = (addr_i == OFF_DATA0) || (addr_i == OFF_DATA1);
  assign rx_pop_o  = rd_i && data_off && !rx_empty_i;

  for (genvar g = 0; g < 2; g++) begin : g_bank
    assign bank_wr_o[g] = wr_i && (addr_i == OFF_DATA0 + ADDR_W'(g));
    assign commit_o[g]  = commit_go && (fill_q == g[0]);
    assign ovf_clr_o[g] = wr_stat && wdata_i[ST_OVF0+g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q <= 1'b0;
      rej_q  <= 1'b0;
    end else begin
      if (commit_go) fill_q <= ~fill_q;
      if (wr_cnt && !commit_go)         rej_q <= 1'b1;
      else if (wr_stat && wdata_i[ST_REJ]) rej_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFF_STATUS: begin
        rdata_o[ST_SEL]    = fill_q;
        rdata_o[ST_BUSY]   = ~free_i[fill_q];
        rdata_o[ST_OVF0]   = ovf_i[0];
        rdata_o[ST_OVF0+1] = ovf_i[1];
        rdata_o[ST_REJ]    = rej_q;
        rdata_o[ST_RXAV]   = ~rx_empty_i;
      end
      OFF_DATA0, OFF_DATA1: rdata_o = rx_empty_i ? '0 : rx_head_i;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/dl_msg_pingpong.sv
`timescale 1ns/1ps
module dl_msg_pingpong
  import dl_pkg::*;
#(
  parameter int unsigned DEPTH    = 96,
  parameter int unsigned RX_DEPTH = 8,
  parameter int unsigned DATA_W   = 8,
  localparam int unsigned PTR_W   = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [3:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  output logic              drain_valid_o,
  output logic [DATA_W-1:0] drain_data_o,
  output logic              drain_last_o,
  input  logic              drain_ready_i
);
  logic [1:0]        bank_wr, commit, ovf_clr, pop_w, free_w, ovf_w, last_w;
  logic [PTR_W-1:0]  count_w;
  logic [DATA_W-1:0] bank_data [2];
  logic              rx_empty, rx_pop;
  logic [DATA_W-1:0] rx_head;
  logic              drain_q;

  dl_host_regs #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni,
    .wr_i(reg_wr_i), .rd_i(reg_rd_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .free_i(free_w), .ovf_i(ovf_w), .rx_empty_i(rx_empty), .rx_head_i(rx_head),
    .bank_wr_o(bank_wr), .commit_o(commit), .count_o(count_w), .ovf_clr_o(ovf_clr),
    .rx_pop_o(rx_pop), .rdata_o(reg_rdata_o)
  );

  for (genvar g = 0; g < 2; g++) begin : g_tx
    assign pop_w[g] = (drain_q == g[0]) && drain_valid_o && drain_ready_i;
    dl_tx_bank #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_bank (
      .clk_i, .rst_ni,
      .wr_i(bank_wr[g]), .wdata_i(reg_wdata_i),
      .commit_i(commit[g]), .count_i(count_w),
      .pop_i(pop_w[g]), .ovf_clr_i(ovf_clr[g]),
      .free_o(free_w[g]), .rdata_o(bank_data[g]), .last_o(last_w[g]), .ovf_o(ovf_w[g])
    );
  end

  dl_rx_fifo #(.DEPTH(RX_DEPTH), .DATA_W(DATA_W)) u_rx (
    .clk_i, .rst_ni,
    .push_i(rx_valid_i), .data_i(rx_data_i),
    .pop_i(rx_pop), .empty_o(rx_empty), .head_o(rx_head)
  );

  // drain follows commit order; commits alternate, so a toggle suffices
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) drain_q <= 1'b0;
    else if (drain_valid_o && drain_ready_i && drain_last_o) drain_q <= ~drain_q;
  end

  assign drain_valid_o = ~free_w[drain_q];
  assign drain_data_o  = bank_data[drain_q];
  assign drain_last_o  = last_w[drain_q];
endmodule

// File: rtl/dl_msg_pingpong_chk.sv
`timescale 1ns/1ps
module dl_msg_pingpong_chk
  import dl_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_wr_i,
  input logic [3:0]        reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic              drain_valid_o,
  input logic [DATA_W-1:0] drain_data_o,
  input logic              drain_last_o,
  input logic              drain_ready_i,
  input logic [1:0]        bank_free,
  input logic [1:0]        bank_ovf,
  input logic              drain_sel
);
  a_r7_hold_on_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drain_valid_o && !drain_ready_i |=>
      drain_valid_o && $stable(drain_data_o) && $stable(drain_last_o));

  a_r7_last_frees: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drain_valid_o && drain_ready_i && drain_last_o |=>
      (($past(drain_sel) == 1'b0) ? bank_free[0] : bank_free[1]));

  a_r5_zero_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_i && reg_addr_i == OFF_COUNT && reg_wdata_i == '0 |=> $stable(bank_free));

  a_r3_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bank_ovf[0] && !(reg_wr_i && reg_addr_i == OFF_STATUS && reg_wdata_i[ST_OVF0]) |=>
      bank_ovf[0]);

  a_r6_busy_no_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_i && reg_addr_i == OFF_COUNT && bank_free == 2'b00 &&
    !(drain_valid_o && drain_ready_i && drain_last_o) |=> bank_free == 2'b00);
endmodule

bind dl_msg_pingpong dl_msg_pingpong_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
  .drain_valid_o(drain_valid_o), .drain_data_o(drain_data_o),
  .drain_last_o(drain_last_o), .drain_ready_i(drain_ready_i),
  .bank_free(free_w), .bank_ovf(ovf_w), .drain_sel(drain_q)
);

// File: tb/dl_msg_pingpong_tb_top.sv
`timescale 1ns/1ps
module dl_msg_pingpong_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic       drain_valid, drain_last;
  logic [7:0] drain_data;
  logic       drain_ready = 1'b0;
  int         n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  dl_msg_pingpong dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_wr_i(reg_wr), .reg_rd_i(reg_rd), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .drain_valid_o(drain_valid), .drain_data_o(drain_data),
    .drain_last_o(drain_last), .drain_ready_i(drain_ready)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input logic [7:0] seed, input int i);
    return seed + 8'(i * 3);
  endfunction

  task automatic host_wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic host_rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic check_status(input logic [7:0] exp, input string tag);
    logic [7:0] s;
    host_rd(4'h0, s);
    chk({tag, " status"}, s, exp);
  endtask

  task automatic fill(input logic [3:0] off, input int n, input logic [7:0] seed);
    for (int i = 0; i < n; i++) host_wr(off, pat(seed, i));
  endtask

  task automatic drain_expect(input int n, input logic [7:0] seed, input string tag);
    @(negedge clk); drain_ready = 1'b1;
    for (int i = 0; i < n; i++) begin
      #1;
      chk({tag, " valid"}, drain_valid, 1);
      chk({tag, " data"}, drain_data, pat(seed, i));
      chk({tag, " last"}, drain_last, (i == n - 1));
      @(negedge clk);
    end
    drain_ready = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] s;
    #1 chk("R1 drain idle in reset", drain_valid, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    host_rd(4'h0, s);
    chk("R1 status after reset", s, 8'h00);
    chk("R1 drain idle after reset", drain_valid, 0);
  endtask

  task automatic t_basic;
    fill(4'h6, 5, 8'h10);
    host_wr(4'h1, 8'd5);
    check_status(8'h01, "R4 commit toggles select");
    drain_expect(5, 8'h10, "R2 in-order drain");
    #1 chk("R7 buffer freed after last", drain_valid, 0);
    check_status(8'h01, "R4 select after drain");
  endtask

  task automatic t_reject;
    host_wr(4'h1, 8'd0);
    check_status(8'h11, "R5 zero count rejected");
    chk("R5 no drain on zero count", drain_valid, 0);
    host_wr(4'h0, 8'h10);
    check_status(8'h01, "R3 reject cleared by w1c");
    host_wr(4'h1, 8'd97);
    check_status(8'h11, "R5 count 97 rejected");
    chk("R5 no drain on count 97", drain_valid, 0);
    host_wr(4'h0, 8'h10);
  endtask

  task automatic t_overflow;
    fill(4'h7, 98, 8'h20);
    check_status(8'h09, "R3 overflow sticky buffer 1");
    host_wr(4'h1, 8'd96);
    check_status(8'h08, "R4 full commit");
    drain_expect(96, 8'h20, "R3 full buffer intact");
    host_wr(4'h0, 8'h08);
    check_status(8'h00, "R3 overflow cleared");
  endtask

  task automatic t_pingpong;
    fill(4'h6, 4, 8'h40);
    host_wr(4'h1, 8'd4);
    check_status(8'h01, "R4 buffer 0 committed");
    @(negedge clk); #1;
    chk("R7 stall valid", drain_valid, 1);
    chk("R7 stall data", drain_data, pat(8'h40, 0));
    repeat (2) @(negedge clk);
    #1 chk("R7 stall data held", drain_data, pat(8'h40, 0));
    chk("R7 stall last low", drain_last, 0);
    fill(4'h7, 3, 8'h60);
    host_wr(4'h1, 8'd3);
    check_status(8'h02, "R6 busy with both held");
    host_wr(4'h6, 8'hEE);
    host_wr(4'h1, 8'd2);
    check_status(8'h12, "R6 count rejected while busy");
    host_wr(4'h0, 8'h10);
    drain_expect(4, 8'h40, "R8 first committed drains first");
    check_status(8'h00, "R6 busy clears after drain");
    drain_expect(3, 8'h60, "R8 second buffer next");
    #1 chk("R8 drain idle", drain_valid, 0);
  endtask

  task automatic t_refill;
    fill(4'h6, 2, 8'h80);
    host_wr(4'h1, 8'd2);
    check_status(8'h01, "R9 commit short refill");
    drain_expect(2, 8'h80, "R9 refill starts at 0");
  endtask

  task automatic t_rx;
    logic [7:0] d;
    @(negedge clk); rx_valid = 1'b1; rx_data = 8'hA1;
    @(negedge clk); rx_data = 8'hB2;
    @(negedge clk); rx_valid = 1'b0;
    check_status(8'h21, "R10 receive available");
    host_rd(4'h6, d);
    chk("R10 first received byte", d, 8'hA1);
    host_rd(4'h7, d);
    chk("R10 second received byte", d, 8'hB2);
    check_status(8'h01, "R10 queue drained");
    host_rd(4'h6, d);
    chk("R10 empty read", d, 8'h00);
    chk("R10 read leaves tx idle", drain_valid, 0);
  endtask

  initial begin
    t_reset;
    t_basic;
    t_reject;
    t_overflow;
    t_pingpong;
    t_refill;
    t_rx;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R1 watchdog act=running exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule